// File: doc/BRIEF.md
# Oversampled Serial Receiver with Receive Queue

This block is the receive half of an asynchronous serial port. It watches a single RX line, uses a free-running baud-clock enable where eight enable pulses make one bit period, and confirms each start bit at its midpoint. After a confirmed start it collects a character of five to eight data bits, least significant bit first. An optional parity bit follows, then a stop bit. Each finished character goes into a small receive queue. From the queue it moves into a single buffer register that software reads.

A data-ready output is high while the buffer register holds a character. Reading the buffer pops the next queued character into it in the same cycle, so data-ready drops only when the buffer and the queue are both empty. Parity, framing and overrun errors are held in sticky flags until a status read clears them. Two interrupt outputs follow the state: one for available data and one for any error flag.

Top module: `uart_rx_top`

## Requirements
- R1: One bit period equals 8 `baud_tick` pulses. A falling edge on the synchronised RX line (high on one tick, low on the next) starts a candidate start bit, and RX is checked again 4 ticks later. If RX is high at that check, the candidate is dropped and nothing is received.
- R2: `cfg_len` selects the character length: 0 = 5 bits, 1 = 6, 2 = 7, 3 = 8. Data bits arrive least significant first. `rbr_data` shows the character with all bits above the selected length at zero.
- R3: With `cfg_par_en` = 1, one parity bit follows the data bits. If `cfg_par_odd` = 0, the data bits plus the parity bit must hold an even number of ones; if `cfg_par_odd` = 1, an odd number. A mismatch sets `parity_err`. A correct parity bit sets no flag.
- R4: A stop bit that samples low sets `framing_err`. The character is still delivered.
- R5: Characters are delivered through `rbr_data` in the order they were received. Up to DEPTH + 1 characters (queue plus buffer register) are held without loss when no reads occur.
- R6: If a character completes while the queue already holds DEPTH entries, that character is discarded and `overrun_err` is set.
- R7: `data_ready` is 1 exactly when the buffer register holds a character. A one-cycle `rbr_rd` pulse loads the next queued character into `rbr_data`, or clears `data_ready` if the queue is empty. While no read occurs, `rbr_data` does not change.
- R8: `parity_err`, `framing_err` and `overrun_err` stay set through idle time and buffer reads until a one-cycle `lsr_rd` pulse clears all three.
- R9: `irq_data_avail` equals `data_ready` in every cycle. `irq_line_status` equals the OR of the three error flags in every cycle. Both therefore follow their cause within one clock, which is well inside one baud tick.
- R10: After a character, a new start bit is recognised only once RX has been seen high. A line held low after a framing error produces a single character, not a stream of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | Baud-clock enable, 8 pulses per bit |
| rx_in | input | 1 | Asynchronous serial input, idle high |
| cfg_len | input | 2 | Character length select (0..3 = 5..8 bits) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| rbr_rd | input | 1 | One-cycle read strobe for the buffer register |
| lsr_rd | input | 1 | One-cycle read strobe for the status flags |
| rbr_data | output | 8 | Buffer register contents |
| data_ready | output | 1 | Buffer register holds a character |
| overrun_err | output | 1 | Sticky overrun flag |
| parity_err | output | 1 | Sticky parity error flag |
| framing_err | output | 1 | Sticky framing error flag |
| irq_data_avail | output | 1 | Received-data-available interrupt |
| irq_line_status | output | 1 | Line-status (error) interrupt |

## Verification
The bench drives a start pulse only two ticks long. A receiver that skipped the midpoint check would take this glitch for a character and raise data-ready. It holds the line low well past a bad stop bit, which a receiver that restarts on a low level instead of a falling edge would turn into a burst of zero characters. It fills the queue and buffer and then sends one more character: an off-by-one capacity would either lose a good character or miss the overrun, and a wrong pop would reorder the data. Short character lengths with high bits set on the line, and both parity senses with good and corrupted parity bits, expose missing zero-padding and an inverted parity check.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP
    } rx_state_e;

    typedef struct packed {
        logic [7:0] data;
        logic       par_bad;
        logic       frm_bad;
    } rx_char_t;

    // index of the final data bit for a length select of 0..3 (5..8 bits)
    function automatic logic [2:0] last_bit_idx(input logic [1:0] len_sel);
        return {1'b1, len_sel};
    endfunction

    // 1 when the received parity bit disagrees with the selected sense
    function automatic logic parity_miss(input logic [7:0] d, input logic pbit,
                                         input logic odd);
        return (^d) ^ pbit ^ odd;
    endfunction

endpackage

// File: rtl/uart_rx_sampler.sv
module uart_rx_sampler
    import uart_rx_pkg::*;
#(
    parameter int OSR = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       baud_tick,
    input  logic       rx_in,
    input  logic [1:0] cfg_len,
    input  logic       cfg_par_en,
    input  logic       cfg_par_odd,
    output logic       char_valid,
    output rx_char_t   char_out
);
    localparam int CW = $clog2(OSR + 1);
    localparam logic [CW-1:0] MID_CNT  = CW'(OSR / 2);
    localparam logic [CW-1:0] FULL_CNT = CW'(OSR);
    localparam logic [CW-1:0] ONE_CNT  = CW'(1);

    logic [1:0] sync_q;
    logic       rx_s;
    logic       rx_prev;
    rx_state_e  state;
    logic [CW-1:0] cnt;
    logic [2:0] bit_idx;
    logic [7:0] shreg;
    logic       par_bad;

    assign rx_s = sync_q[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q     <= 2'b11;
            rx_prev    <= 1'b1;
            state      <= RX_IDLE;
            cnt        <= '0;
            bit_idx    <= '0;
            shreg      <= '0;
            par_bad    <= 1'b0;
            char_valid <= 1'b0;
            char_out   <= '0;
        end else begin
            sync_q     <= {sync_q[0], rx_in};
            char_valid <= 1'b0;
            if (baud_tick) begin
                rx_prev <= rx_s;
                if (state != RX_IDLE) begin
                    cnt <= cnt + ONE_CNT;
                end
                case (state)
                    RX_IDLE: begin
                        if (rx_prev && !rx_s) begin
                            state <= RX_START;
                            cnt   <= ONE_CNT;
                        end
                    end
                    RX_START: begin
                        if (cnt == MID_CNT) begin
                            cnt <= ONE_CNT;
                            if (rx_s) begin
                                state <= RX_IDLE;
                            end else begin
                                state   <= RX_DATA;
                                bit_idx <= '0;
                                shreg   <= '0;
                                par_bad <= 1'b0;
                            end
                        end
                    end
                    RX_DATA: begin
                        if (cnt == FULL_CNT) begin
                            cnt            <= ONE_CNT;
                            shreg[bit_idx] <= rx_s;
                            if (bit_idx == last_bit_idx(cfg_len)) begin
                                state <= cfg_par_en ? RX_PAR : RX_STOP;
                            end else begin
                                bit_idx <= bit_idx + 3'd1;
                            end
                        end
                    end
                    RX_PAR: begin
                        if (cnt == FULL_CNT) begin
                            cnt     <= ONE_CNT;
                            par_bad <= parity_miss(shreg, rx_s, cfg_par_odd);
                            state   <= RX_STOP;
                        end
                    end
                    RX_STOP: begin
                        if (cnt == FULL_CNT) begin
                            char_valid       <= 1'b1;
                            char_out.data    <= shreg;
                            char_out.par_bad <= par_bad;
                            char_out.frm_bad <= !rx_s;
                            state            <= RX_IDLE;
                        end
                    end
                    default: state <= RX_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue #(
    parameter int W     = 8,
    parameter int DEPTH = 4,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNTW = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            push,
    input  logic [W-1:0]    din,
    input  logic            pop,
    output logic [W-1:0]    dout,
    output logic            full,
    output logic            empty,
    output logic [CNTW-1:0] count
);
    localparam logic [PW-1:0]   LAST_PTR = PW'(DEPTH - 1);
    localparam logic [CNTW-1:0] FULL_CNT = CNTW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wptr, rptr;
    logic          do_push, do_pop;

    assign full    = (count == FULL_CNT);
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rptr];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wptr] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) begin
                wptr <= (wptr == LAST_PTR) ? '0 : wptr + PW'(1);
            end
            if (do_pop) begin
                rptr <= (rptr == LAST_PTR) ? '0 : rptr + PW'(1);
            end
            case ({do_push, do_pop})
                2'b10:   count <= count + CNTW'(1);
                2'b01:   count <= count - CNTW'(1);
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/uart_rx_stage.sv
module uart_rx_stage (
    input  logic       clk,
    input  logic       rst,
    input  logic       char_valid,
    input  logic       char_par_bad,
    input  logic       char_frm_bad,
    input  logic       q_full,
    input  logic       q_empty,
    input  logic [7:0] q_head,
    input  logic       rbr_rd,
    input  logic       lsr_rd,
    output logic       q_push,
    output logic       q_pop,
    output logic [7:0] rbr_data,
    output logic       data_ready,
    output logic       overrun_err,
    output logic       parity_err,
    output logic       framing_err
);
    logic overrun_evt, pe_evt, fe_evt;

    assign q_push      = char_valid && !q_full;
    assign overrun_evt = char_valid && q_full;
    assign pe_evt      = q_push && char_par_bad;
    assign fe_evt      = q_push && char_frm_bad;
    assign q_pop       = !q_empty && (!data_ready || rbr_rd);

    always_ff @(posedge clk) begin
        if (rst) begin
            rbr_data   <= '0;
            data_ready <= 1'b0;
        end else if (q_pop) begin
            rbr_data   <= q_head;
            data_ready <= 1'b1;
        end else if (rbr_rd) begin
            data_ready <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            overrun_err <= 1'b0;
            parity_err  <= 1'b0;
            framing_err <= 1'b0;
        end else begin
            overrun_err <= overrun_evt || (overrun_err && !lsr_rd);
            parity_err  <= pe_evt      || (parity_err  && !lsr_rd);
            framing_err <= fe_evt      || (framing_err && !lsr_rd);
        end
    end

endmodule

// File: rtl/uart_rx_top.sv
module uart_rx_top
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int OSR   = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       baud_tick,
    input  logic       rx_in,
    input  logic [1:0] cfg_len,
    input  logic       cfg_par_en,
    input  logic       cfg_par_odd,
    input  logic       rbr_rd,
    input  logic       lsr_rd,
    output logic [7:0] rbr_data,
    output logic       data_ready,
    output logic       overrun_err,
    output logic       parity_err,
    output logic       framing_err,
    output logic       irq_data_avail,
    output logic       irq_line_status
);
    localparam int CNTW = $clog2(DEPTH + 1);

    logic            char_valid;
    rx_char_t        char_out;
    logic            q_push, q_pop, q_full, q_empty;
    logic [7:0]      q_head;
    logic [CNTW-1:0] fifo_count;

    uart_rx_sampler #(.OSR(OSR)) i_sampler (
        .clk        (clk),
        .rst        (rst),
        .baud_tick  (baud_tick),
        .rx_in      (rx_in),
        .cfg_len    (cfg_len),
        .cfg_par_en (cfg_par_en),
        .cfg_par_odd(cfg_par_odd),
        .char_valid (char_valid),
        .char_out   (char_out)
    );

    uart_rx_queue #(.W(8), .DEPTH(DEPTH)) i_queue (
        .clk  (clk),
        .rst  (rst),
        .push (q_push),
        .din  (char_out.data),
        .pop  (q_pop),
        .dout (q_head),
        .full (q_full),
        .empty(q_empty),
        .count(fifo_count)
    );

    uart_rx_stage i_stage (
        .clk         (clk),
        .rst         (rst),
        .char_valid  (char_valid),
        .char_par_bad(char_out.par_bad),
        .char_frm_bad(char_out.frm_bad),
        .q_full      (q_full),
        .q_empty     (q_empty),
        .q_head      (q_head),
        .rbr_rd      (rbr_rd),
        .lsr_rd      (lsr_rd),
        .q_push      (q_push),
        .q_pop       (q_pop),
        .rbr_data    (rbr_data),
        .data_ready  (data_ready),
        .overrun_err (overrun_err),
        .parity_err  (parity_err),
        .framing_err (framing_err)
    );

    assign irq_data_avail  = data_ready;
    assign irq_line_status = overrun_err || parity_err || framing_err;

endmodule

// File: rtl/uart_rx_checker.sv
module uart_rx_checker #(
    parameter int DEPTH = 4,
    parameter int CNTW  = 3
) (
    input logic            clk,
    input logic            rst,
    input logic            rbr_rd,
    input logic            lsr_rd,
    input logic            char_valid,
    input logic [CNTW-1:0] fifo_count,
    input logic [7:0]      rbr_data,
    input logic            data_ready,
    input logic            overrun_err,
    input logic            parity_err,
    input logic            framing_err
);
    a_r5_queue_bound: assert property (@(posedge clk) disable iff (rst)
        fifo_count <= CNTW'(DEPTH));

    a_r6_overrun_sets: assert property (@(posedge clk) disable iff (rst)
        (char_valid && fifo_count == CNTW'(DEPTH)) |=> overrun_err);

    a_r7_ready_drops: assert property (@(posedge clk) disable iff (rst)
        (rbr_rd && data_ready && fifo_count == '0) |=> !data_ready);

    a_r7_buffer_holds: assert property (@(posedge clk) disable iff (rst)
        (data_ready && !rbr_rd) |=> (data_ready && $stable(rbr_data)));

    a_r8_parity_sticky: assert property (@(posedge clk) disable iff (rst)
        (parity_err && !lsr_rd) |=> parity_err);

    a_r8_framing_sticky: assert property (@(posedge clk) disable iff (rst)
        (framing_err && !lsr_rd) |=> framing_err);

    a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
        (overrun_err && !lsr_rd) |=> overrun_err);

    a_r8_status_clear: assert property (@(posedge clk) disable iff (rst)
        (lsr_rd && !char_valid) |=> (!parity_err && !framing_err && !overrun_err));

endmodule

bind uart_rx_top uart_rx_checker #(.DEPTH(DEPTH), .CNTW(CNTW)) i_uart_rx_checker (
    .clk        (clk),
    .rst        (rst),
    .rbr_rd     (rbr_rd),
    .lsr_rd     (lsr_rd),
    .char_valid (char_valid),
    .fifo_count (fifo_count),
    .rbr_data   (rbr_data),
    .data_ready (data_ready),
    .overrun_err(overrun_err),
    .parity_err (parity_err),
    .framing_err(framing_err)
);

// File: tb/test_uart_rx_top.sv
module test_uart_rx_top;
    localparam int DEPTH = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       baud_tick = 1'b0;
    logic       rx_in = 1'b1;
    logic [1:0] cfg_len = 2'd3;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic       rbr_rd = 1'b0;
    logic       lsr_rd = 1'b0;
    logic [7:0] rbr_data;
    logic       data_ready, overrun_err, parity_err, framing_err;
    logic       irq_data_avail, irq_line_status;

    int checks = 0;
    int failures = 0;
    int tdiv = 0;
    int cyc = 0;
    bit running = 0;
    bit done = 0;

    logic [7:0] exp_q[$];
    bit exp_pe = 0, exp_fe = 0, exp_oe = 0;

    always #4 clk = ~clk;

    uart_rx_top #(.DEPTH(DEPTH)) i_uart_rx_top (
        .clk(clk), .rst(rst), .baud_tick(baud_tick), .rx_in(rx_in),
        .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .rbr_rd(rbr_rd), .lsr_rd(lsr_rd), .rbr_data(rbr_data),
        .data_ready(data_ready), .overrun_err(overrun_err),
        .parity_err(parity_err), .framing_err(framing_err),
        .irq_data_avail(irq_data_avail), .irq_line_status(irq_line_status)
    );

    // baud enable: one pulse every 4 clocks, changed away from the active edge
    always @(negedge clk) begin
        tdiv = (tdiv == 3) ? 0 : tdiv + 1;
        baud_tick = (tdiv == 3);
    end

    task automatic check(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // R9: interrupt outputs compared every cycle
    always @(negedge clk) begin
        if (running) begin
            check("R9 irq_data_avail", int'(irq_data_avail), int'(data_ready));
            check("R9 irq_line_status", int'(irq_line_status),
                  int'(parity_err | framing_err | overrun_err));
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000 && !done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic wait_ticks(input int n);
        repeat (n) begin
            @(posedge clk);
            while (!baud_tick) @(posedge clk);
        end
        @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input int nb, input bit pen,
                        input bit podd, input bit flip, input bit stopv,
                        input int hold_low);
        logic [7:0] masked;
        masked = d & 8'((1 << nb) - 1);
        cfg_len = 2'(nb - 5);
        cfg_par_en = pen;
        cfg_par_odd = podd;
        wait_ticks(1);
        rx_in = 1'b0;
        wait_ticks(8);
        for (int i = 0; i < nb; i++) begin
            rx_in = d[i];
            wait_ticks(8);
        end
        if (pen) begin
            rx_in = (^masked) ^ podd ^ flip;
            wait_ticks(8);
        end
        rx_in = stopv;
        wait_ticks(8);
        if (hold_low > 0) wait_ticks(hold_low);
        rx_in = 1'b1;
        wait_ticks(2);
        if (exp_q.size() < DEPTH + 1) begin
            exp_q.push_back(masked);
            if (pen && flip) exp_pe = 1;
            if (!stopv) exp_fe = 1;
        end else begin
            exp_oe = 1;
        end
    endtask

    task automatic read_rbr(input string tag);
        check({tag, " data_ready before read"}, int'(data_ready), 1);
        check({tag, " rbr_data"}, int'(rbr_data), int'(exp_q[0]));
        rbr_rd = 1'b1;
        @(negedge clk);
        rbr_rd = 1'b0;
        void'(exp_q.pop_front());
        @(negedge clk);
        check({tag, " data_ready after read"}, int'(data_ready), int'(exp_q.size() > 0));
        if (exp_q.size() > 0)
            check({tag, " next rbr_data"}, int'(rbr_data), int'(exp_q[0]));
    endtask

    task automatic read_lsr(input string tag);
        check({tag, " parity_err"}, int'(parity_err), int'(exp_pe));
        check({tag, " framing_err"}, int'(framing_err), int'(exp_fe));
        check({tag, " overrun_err"}, int'(overrun_err), int'(exp_oe));
        lsr_rd = 1'b1;
        @(negedge clk);
        lsr_rd = 1'b0;
        exp_pe = 0; exp_fe = 0; exp_oe = 0;
        @(negedge clk);
        check({tag, " flags cleared"},
              int'({parity_err, framing_err, overrun_err}), 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        running = 1;
        check("R7 reset data_ready", int'(data_ready), 0);
        check("R8 reset flags", int'({parity_err, framing_err, overrun_err}), 0);
        check("R9 reset irqs", int'({irq_data_avail, irq_line_status}), 0);
        wait_ticks(4);

        // R2: every length, high bits driven 1 on the line where possible
        send(8'hA5, 8, 0, 0, 0, 1, 0);
        read_rbr("R2 len8");
        send(8'hF5, 5, 0, 0, 0, 1, 0);
        read_rbr("R2 len5 padded");
        send(8'hFF, 6, 0, 0, 0, 1, 0);
        read_rbr("R2 len6 padded");
        send(8'h81, 7, 0, 0, 0, 1, 0);
        read_rbr("R2 len7 padded");
        read_lsr("R2 no errors");

        // R3: parity senses, good and corrupted
        send(8'h5A, 8, 1, 0, 0, 1, 0);
        read_lsr("R3 even good");
        read_rbr("R3 even good");
        send(8'h5B, 8, 1, 0, 1, 1, 0);
        read_rbr("R3 even bad");
        wait_ticks(20);
        check("R8 parity_err held after rbr read", int'(parity_err), 1);
        read_lsr("R3 even bad");
        send(8'h07, 7, 1, 1, 0, 1, 0);
        read_lsr("R3 odd good");
        read_rbr("R3 odd good");
        send(8'h13, 5, 1, 1, 1, 1, 0);
        read_rbr("R3 odd bad");
        read_lsr("R3 odd bad");

        // R4: stop bit low
        send(8'h3C, 8, 0, 0, 0, 0, 0);
        read_rbr("R4 framing");
        read_lsr("R4 framing");

        // R10: line held low long after a bad stop bit
        send(8'h00, 8, 0, 0, 0, 0, 40);
        wait_ticks(4);
        check("R10 single char queued", int'(exp_q.size()), 1);
        read_rbr("R10 break");
        read_lsr("R10 break");

        // R5 / R6: fill buffer and queue, then one more
        for (int i = 0; i < DEPTH + 2; i++) begin
            send(8'(8'h10 + i), 8, 0, 0, 0, 1, 0);
        end
        check("R6 overrun_err", int'(overrun_err), 1);
        read_lsr("R6 overrun");
        for (int i = 0; i < DEPTH + 1; i++) begin
            check("R5 order", int'(rbr_data), 8'h10 + i);
            read_rbr("R5 drain");
        end
        check("R7 empty after drain", int'(data_ready), 0);

        // R1: short glitch rejected, receiver still works afterwards
        wait_ticks(1);
        rx_in = 1'b0;
        wait_ticks(2);
        rx_in = 1'b1;
        wait_ticks(100);
        check("R1 glitch no data", int'(data_ready), 0);
        check("R1 glitch no flags", int'({parity_err, framing_err, overrun_err}), 0);
        send(8'hC3, 8, 0, 0, 0, 1, 0);
        read_rbr("R1 after glitch");

        done = 1;
        running = 0;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule